// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation buffer. Each slot holds a virtual page number tag, a physical page number, an 8-bit address-space number, a global flag that lets the slot match in any address space, per-mode read and write enable masks, and fault-on-read and fault-on-write flags. A lookup presents a page number and the current address-space number. In the same cycle, combinationally from the stored state, it returns a hit flag, the slot index, the page number and the permission fields.

New translations come in through a valid/ready insert port. An insert is accepted on a rising edge where `ins_valid` and `ins_ready` are both high. `ins_ready` is low in any cycle where a flush command is raised, and the producer must hold the insert until it is accepted. An accepted insert writes the slot named by a rotating victim pointer and then advances the pointer.

Three plain control pulses invalidate entries. One clears everything. One clears every non-global entry. One clears the entries that one page number maps in one address space. Permission checking and table walking belong to the surrounding logic.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global flag is set or whose stored address-space number equals `lk_asn`.
- R2: On a hit, `lk_ppn`, `lk_global`, `lk_rd_en`, `lk_wr_en`, `lk_fault_rd` and `lk_fault_wr` show the fields of the hitting slot in the same cycle, with no register between the lookup inputs and these outputs.
- R3: When several slots hit, `lk_idx` and the fields belong to the lowest-numbered hitting slot.
- R4: An accepted insert writes the slot at the victim pointer, marks it valid and advances the pointer by one. The pointer wraps from slot ENTRIES-1 to slot 0.
- R5: An insert into a slot that already holds a valid entry replaces it, and the old translation no longer hits.
- R6: `fl_all` invalidates every slot and sets the victim pointer to 0.
- R7: `fl_proc` invalidates every slot whose global flag is clear and leaves global slots valid.
- R8: `fl_addr` invalidates every valid slot whose tag equals `fl_vpn` and that is global or holds `fl_asn`. Other slots stay valid.
- R9: A flush takes effect at the clock edge that samples it. A lookup in the cycle where the flush is raised sees the state before the flush.
- R10: `ins_ready` is low in any cycle where `fl_all`, `fl_proc` or `fl_addr` is high, and no insert is written in that cycle.
- R11: After reset no lookup hits and the first insert lands in slot 0.
- R12: `lk_hit` is low whenever `lk_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asn | input | 8 | Current address-space number |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | $clog2(ENTRIES) | Index of the matching slot |
| lk_ppn | output | PPN_W | Physical page number of the match |
| lk_global | output | 1 | Global flag of the match |
| lk_rd_en | output | 4 | Read enable per mode |
| lk_wr_en | output | 4 | Write enable per mode |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |
| ins_valid | input | 1 | Insert offered |
| ins_ready | output | 1 | Insert can be accepted |
| ins_vpn | input | VPN_W | Tag to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_asn | input | 8 | Address-space number to insert |
| ins_global | input | 1 | Global flag to insert |
| ins_rd_en | input | 4 | Read enables to insert |
| ins_wr_en | input | 4 | Write enables to insert |
| ins_fault_rd | input | 1 | Fault-on-read to insert |
| ins_fault_wr | input | 1 | Fault-on-write to insert |
| fl_all | input | 1 | Invalidate all slots |
| fl_proc | input | 1 | Invalidate non-global slots |
| fl_addr | input | 1 | Invalidate one page in one space |
| fl_vpn | input | VPN_W | Page number for `fl_addr` |
| fl_asn | input | 8 | Address-space number for `fl_addr` |

## Verification
The bench builds the block with ENTRIES=4, VPN_W=12 and PPN_W=10. With four slots, a handful of inserts is enough to wrap the victim pointer and to overwrite a live slot. The same small table can hold one page number in a global and a non-global slot at once, which exercises the lowest-index rule. It also leaves slots at both ends of the table for the selective flushes to keep or remove.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int ASN_W = 8;
  localparam int MODES = 4;

  typedef struct packed {
    logic [MODES-1:0] rd_en;
    logic [MODES-1:0] wr_en;
    logic             fault_rd;
    logic             fault_wr;
  } perm_t;

  // slot matches: live, same tag, and global or same space
  function automatic logic slot_match(input logic live, input logic tag_eq,
                                      input logic glob, input logic asn_eq);
    return live & tag_eq & (glob | asn_eq);
  endfunction
endpackage

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  ptr <= '0;
    else if (adv)       ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr == LAST) |=> (ptr == '0));
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
  assert_ptr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0));
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [VPN_W-1:0]                wr_vpn,
  input  logic [PPN_W-1:0]                wr_ppn,
  input  logic [ASN_W-1:0]                wr_asn,
  input  logic                            wr_glob,
  input  perm_t                           wr_perm,
  input  logic                            fl_all,
  input  logic                            fl_proc,
  input  logic                            fl_addr,
  input  logic [VPN_W-1:0]                fl_vpn,
  input  logic [ASN_W-1:0]                fl_asn,
  output logic [ENTRIES-1:0]              live_o,
  output logic [ENTRIES-1:0]              glob_o,
  output logic [ENTRIES-1:0][VPN_W-1:0]   tag_o,
  output logic [ENTRIES-1:0][PPN_W-1:0]   ppn_o,
  output logic [ENTRIES-1:0][ASN_W-1:0]   asn_o,
  output perm_t [ENTRIES-1:0]             perm_o
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic kill, load;
    assign kill = fl_all
                | (fl_proc & ~glob_o[i])
                | (fl_addr & slot_match(live_o[i], tag_o[i] == fl_vpn,
                                        glob_o[i], asn_o[i] == fl_asn));
    assign load = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)     live_o[i] <= 1'b0;
      else if (kill)  live_o[i] <= 1'b0;
      else if (load)  live_o[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        glob_o[i] <= 1'b0;
        tag_o[i]  <= '0;
        ppn_o[i]  <= '0;
        asn_o[i]  <= '0;
        perm_o[i] <= '0;
      end else if (load) begin
        glob_o[i] <= wr_glob;
        tag_o[i]  <= wr_vpn;
        ppn_o[i]  <= wr_ppn;
        asn_o[i]  <= wr_asn;
        perm_o[i] <= wr_perm;
      end
    end
  end

  assert_flush_all_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> (live_o == '0));
  assert_proc_drops_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_proc |=> ((live_o & ~glob_o) == '0));
  assert_proc_keeps_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_proc && !fl_all && !fl_addr && !wr_en) |=>
      ((live_o & glob_o) == $past(live_o & glob_o)));
  assert_insert_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fl_all && !fl_proc && !fl_addr) |=> live_o[$past(wr_idx)]);
  assert_addr_keeps_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_addr && !fl_all && !fl_proc && !wr_en) |=>
      ((live_o & ~$past(live_o)) == '0));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req,
  input  logic [VPN_W-1:0]              vpn,
  input  logic [ASN_W-1:0]              asn,
  input  logic [ENTRIES-1:0]            live,
  input  logic [ENTRIES-1:0]            glob,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag,
  input  logic [ENTRIES-1:0][ASN_W-1:0] sasn,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] mv;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign mv[i] = req & slot_match(live[i], tag[i] == vpn, glob[i], sasn[i] == asn);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (mv[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assert_hit_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> req);
  assert_hit_slot_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (live[idx] && tag[idx] == vpn && (glob[idx] || sasn[idx] == asn)));
  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((mv & ~({ENTRIES{1'b1}} << idx)) == '0));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [7:0]       lk_asn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_global,
  output logic [3:0]       lk_rd_en,
  output logic [3:0]       lk_wr_en,
  output logic             lk_fault_rd,
  output logic             lk_fault_wr,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [7:0]       ins_asn,
  input  logic             ins_global,
  input  logic [3:0]       ins_rd_en,
  input  logic [3:0]       ins_wr_en,
  input  logic             ins_fault_rd,
  input  logic             ins_fault_wr,
  input  logic             fl_all,
  input  logic             fl_proc,
  input  logic             fl_addr,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [7:0]       fl_asn
);
  logic                          ins_fire;
  logic [IDX_W-1:0]              victim;
  logic [ENTRIES-1:0]            live, glob;
  logic [ENTRIES-1:0][VPN_W-1:0] tag;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn;
  logic [ENTRIES-1:0][ASN_W-1:0] sasn;
  perm_t [ENTRIES-1:0]           perm;
  perm_t                         ins_perm, sel_perm;

  assign ins_ready = !(fl_all || fl_proc || fl_addr);
  assign ins_fire  = ins_valid && ins_ready;
  assign ins_perm  = '{rd_en: ins_rd_en, wr_en: ins_wr_en,
                       fault_rd: ins_fault_rd, fault_wr: ins_fault_wr};

  tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(fl_all), .adv(ins_fire), .ptr(victim));

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ins_fire), .wr_idx(victim), .wr_vpn(ins_vpn), .wr_ppn(ins_ppn),
    .wr_asn(ins_asn), .wr_glob(ins_global), .wr_perm(ins_perm),
    .fl_all(fl_all), .fl_proc(fl_proc), .fl_addr(fl_addr),
    .fl_vpn(fl_vpn), .fl_asn(fl_asn),
    .live_o(live), .glob_o(glob), .tag_o(tag), .ppn_o(ppn),
    .asn_o(sasn), .perm_o(perm));

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .clk(clk), .rst_n(rst_n), .req(lk_valid), .vpn(lk_vpn), .asn(lk_asn),
    .live(live), .glob(glob), .tag(tag), .sasn(sasn),
    .hit(lk_hit), .idx(lk_idx));

  assign sel_perm    = perm[lk_idx];
  assign lk_ppn      = ppn[lk_idx];
  assign lk_global   = glob[lk_idx];
  assign lk_rd_en    = sel_perm.rd_en;
  assign lk_wr_en    = sel_perm.wr_en;
  assign lk_fault_rd = sel_perm.fault_rd;
  assign lk_fault_wr = sel_perm.fault_wr;

  assert_flush_blocks_insert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_all || fl_proc || fl_addr) |-> !ins_ready);
  assert_insert_lands_victim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> (tag[$past(victim)] == $past(ins_vpn) && ppn[$past(victim)] == $past(ins_ppn)));
endmodule

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, VW = 12, PW = 10;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0; logic [VW-1:0] lk_vpn = '0; logic [7:0] lk_asn = '0;
  logic lk_hit; logic [1:0] lk_idx; logic [PW-1:0] lk_ppn; logic lk_global;
  logic [3:0] lk_rd_en, lk_wr_en; logic lk_fault_rd, lk_fault_wr;
  logic ins_valid = 0, ins_ready; logic [VW-1:0] ins_vpn = '0; logic [PW-1:0] ins_ppn = '0;
  logic [7:0] ins_asn = '0; logic ins_global = 0; logic [3:0] ins_rd_en = '0, ins_wr_en = '0;
  logic ins_fault_rd = 0, ins_fault_wr = 0;
  logic fl_all = 0, fl_proc = 0, fl_addr = 0; logic [VW-1:0] fl_vpn = '0; logic [7:0] fl_asn = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // permissions derived from the page number so each slot differs
  task automatic insert(input int vpn, input int ppn, input int asn, input bit g);
    @(negedge clk);
    ins_valid = 1; ins_vpn = VW'(vpn); ins_ppn = PW'(ppn); ins_asn = 8'(asn);
    ins_global = g; ins_rd_en = 4'(vpn); ins_wr_en = ~4'(vpn);
    ins_fault_rd = vpn[4]; ins_fault_wr = vpn[5];
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic look(input string req, input int vpn, input int asn,
                      input bit eh, input int eidx, input int eppn);
    @(negedge clk);
    lk_valid = 1; lk_vpn = VW'(vpn); lk_asn = 8'(asn);
    #1;
    chk(req, lk_hit, eh);
    if (eh) begin
      chk(req, lk_idx, eidx);
      chk(req, lk_ppn, eppn);
    end
    lk_valid = 0;
  endtask

  task automatic t_reset;  // R11
    look("R11 empty after reset", 'h10, 1, 0, 0, 0);
    insert('h10, 'h1A, 1, 0);
    look("R11 first insert at slot 0", 'h10, 1, 1, 0, 'h1A);
  endtask

  task automatic t_basic;  // R1 R2 R12
    insert('h20, 'h2B, 2, 1);                     // slot 1 global
    look("R1 wrong space misses", 'h10, 2, 0, 0, 0);
    look("R1 global hits any space", 'h20, 7, 1, 1, 'h2B);
    @(negedge clk);
    lk_valid = 1; lk_vpn = VW'('h10); lk_asn = 8'd1; #1;
    chk("R2 rd_en", lk_rd_en, 4'h0);
    chk("R2 wr_en", lk_wr_en, 4'hF);
    chk("R2 fault_rd", lk_fault_rd, 1);
    chk("R2 fault_wr", lk_fault_wr, 0);
    chk("R2 global", lk_global, 0);
    lk_valid = 0; #1;
    chk("R12 no hit without request", lk_hit, 0);
  endtask

  task automatic t_priority;  // R3
    insert('h10, 'h3C, 5, 1);                     // slot 2 global, same tag as slot 0
    look("R3 only global copy", 'h10, 5, 1, 2, 'h3C);
    look("R3 lowest of two", 'h10, 1, 1, 0, 'h1A);
  endtask

  task automatic t_wrap;  // R4 R5
    insert('h30, 'h4D, 3, 0);                     // slot 3
    insert('h40, 'h5E, 1, 0);                     // wraps to slot 0
    look("R4 wrap to slot 0", 'h40, 1, 1, 0, 'h5E);
    look("R5 old slot-0 entry gone", 'h10, 1, 1, 2, 'h3C);
    look("R4 slot 3 written", 'h30, 3, 1, 3, 'h4D);
  endtask

  task automatic t_flush_addr;  // R8 R9 R10
    @(negedge clk);
    fl_addr = 1; fl_vpn = VW'('h30); fl_asn = 8'd4;
    @(negedge clk); fl_addr = 0;
    look("R8 other space kept", 'h30, 3, 1, 3, 'h4D);
    @(negedge clk);
    fl_addr = 1; fl_vpn = VW'('h30); fl_asn = 8'd3;
    ins_valid = 1; ins_vpn = VW'('h77); ins_ppn = '0; ins_asn = 8'd3; ins_global = 0;
    lk_valid = 1; lk_vpn = VW'('h30); lk_asn = 8'd3; #1;
    chk("R9 same-cycle lookup sees old", lk_hit, 1);
    chk("R10 ready low on flush", ins_ready, 0);
    @(negedge clk); fl_addr = 0; ins_valid = 0; lk_valid = 0;
    look("R8 matching entry removed", 'h30, 3, 0, 0, 0);
    look("R10 blocked insert absent", 'h77, 3, 0, 0, 0);
    @(negedge clk);
    fl_addr = 1; fl_vpn = VW'('h20); fl_asn = 8'd9;
    @(negedge clk); fl_addr = 0;
    look("R8 global removed any space", 'h20, 2, 0, 0, 0);
    look("R8 unrelated kept", 'h40, 1, 1, 0, 'h5E);
  endtask

  task automatic t_flush_proc;  // R7
    @(negedge clk); fl_proc = 1;
    @(negedge clk); fl_proc = 0;
    look("R7 local removed", 'h40, 1, 0, 0, 0);
    look("R7 global kept", 'h10, 6, 1, 2, 'h3C);
  endtask

  task automatic t_flush_all;  // R6
    insert('h50, 'h11, 1, 1);                     // pointer now nonzero
    @(negedge clk); fl_all = 1;
    @(negedge clk); fl_all = 0;
    look("R6 global cleared", 'h10, 6, 0, 0, 0);
    look("R6 newest cleared", 'h50, 1, 0, 0, 0);
    insert('h60, 'h22, 1, 0);
    look("R6 pointer back to 0", 'h60, 1, 1, 0, 'h22);
  endtask

  task automatic t_reset_mid;  // R11
    insert('h61, 'h23, 1, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    look("R11 reset empties", 'h61, 1, 0, 0, 0);
    insert('h62, 'h24, 1, 0);
    look("R11 reset pointer", 'h62, 1, 1, 0, 'h24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_priority();
    t_wrap();
    t_flush_addr();
    t_flush_proc();
    t_flush_all();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule